// File: doc/BRIEF.md
# Load/Store Request Sequencer

This block drives one load/store port of a simple in-order core. The core hands it one memory operation at a time. The operation is a read or a write, and it may carry lock, swap and no-access qualifiers. The sequencer turns the operation into a bus command and offers it downstream on a valid/ready handshake. It then waits for the response and hands the result back to the core as a one-cycle response strobe.

A downstream refusal is held inside the block. The block replays the request when a one-cycle retry pulse arrives. A negatively acknowledged response makes the block send the same request again.

Some operations never reach the bus: a store-conditional whose lock check has already failed, and an operation marked no-access. These complete locally. A drain request is acknowledged only once the block has no access in flight.

Top module: `memreq_seq`

## Requirements
- R1: After reset `core_ready` is 1, and `dn_valid`, `rsp_valid` and `drain_ack` are 0.
- R2: `dn_cmd` encodes the operation as follows. A read is 0. A read with `core_locked` is 1 (load-locked). A write is 2. A write with `core_locked` is 3 (store-conditional), and lock takes priority over swap. A write with `core_swap` and no lock is 4. `core_swap` has no effect on reads. `dn_addr` and `dn_wdata` carry the accepted address and data.
- R3: A cycle with `dn_valid` high and `dn_ready` low is a refusal. In the next cycle `dn_valid` drops and the request is held. The cycle after a `dn_retry` pulse, `dn_valid` rises again with the same command, address and data.
- R4: A response with `up_nack` high makes `dn_valid` rise again in the next cycle with the same request. If that resend is refused, the block waits for a retry pulse as in R3.
- R5: `proto_err` is high in any cycle where `dn_retry` is high while no refused request is held.
- R6: A write with both `core_locked` and `core_lockfail` set makes no downstream request. It completes with `rsp_valid` and `rsp_local` high one cycle after acceptance, with `rsp_data` 0.
- R7: An operation with `core_noacc` set completes locally in the same way as R6.
- R8: When a non-nacked response is sampled while an access is in flight, `rsp_valid` is high for exactly the next cycle. In that cycle `rsp_data` equals `up_data` and `rsp_local` is 0. A response sampled while no access is in flight is ignored.
- R9: At most one operation is in flight. `core_ready` stays low from acceptance until the cycle after the response strobe.
- R10: `drain_ack` is high while `drain_req` is high and no operation is in flight. While draining, new operations are held off (`core_ready` is 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_valid | input | 1 | Core offers an operation |
| core_ready | output | 1 | Sequencer can accept an operation |
| core_write | input | 1 | 1 = write, 0 = read |
| core_locked | input | 1 | Locked qualifier (load-locked / store-conditional) |
| core_swap | input | 1 | Swap qualifier for writes |
| core_noacc | input | 1 | Operation needs no memory access |
| core_lockfail | input | 1 | Lock check already failed for a locked write |
| core_addr | input | AW | Operation address |
| core_wdata | input | DW | Write data |
| rsp_valid | output | 1 | One-cycle completion strobe |
| rsp_data | output | DW | Returned data |
| rsp_local | output | 1 | Completion made without a bus access |
| dn_valid | output | 1 | Downstream request valid |
| dn_ready | input | 1 | Downstream accepts the request |
| dn_cmd | output | 3 | Bus command code |
| dn_addr | output | AW | Request address |
| dn_wdata | output | DW | Request write data |
| dn_retry | input | 1 | Pulse: downstream can take the refused request |
| up_valid | input | 1 | Downstream response valid |
| up_nack | input | 1 | Response is a negative acknowledge |
| up_data | input | DW | Response data |
| proto_err | output | 1 | Retry pulse received with nothing held |
| drain_req | input | 1 | Request to quiesce |
| drain_ack | output | 1 | Quiesced: nothing in flight |

## Verification
A corrupted state register shows up at the ports within one cycle. A lost held request leaves `dn_valid` low after the retry pulse. A lost nack replay leaves the core waiting with no bus activity. A wrong completion path appears as `rsp_local` or `rsp_data` being wrong on the single strobe cycle. Drain mistakes appear as `drain_ack` rising while an access is still in flight, or never rising after the strobe. So every check samples the cycle right after the triggering edge.

// File: rtl/memreq_seq.sv
module memreq_seq #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          core_valid,
  output logic          core_ready,
  input  logic          core_write,
  input  logic          core_locked,
  input  logic          core_swap,
  input  logic          core_noacc,
  input  logic          core_lockfail,
  input  logic [AW-1:0] core_addr,
  input  logic [DW-1:0] core_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          rsp_local,
  output logic          dn_valid,
  input  logic          dn_ready,
  output logic [2:0]    dn_cmd,
  output logic [AW-1:0] dn_addr,
  output logic [DW-1:0] dn_wdata,
  input  logic          dn_retry,
  input  logic          up_valid,
  input  logic          up_nack,
  input  logic [DW-1:0] up_data,
  output logic          proto_err,
  input  logic          drain_req,
  output logic          drain_ack
);
  localparam logic [2:0] C_RD = 3'd0, C_RDLK = 3'd1, C_WR = 3'd2, C_WRCOND = 3'd3, C_SWAP = 3'd4;

  typedef enum logic [2:0] {S_IDLE, S_ISSUE, S_HOLD, S_WAIT, S_RESP} st_t;
  st_t st;

  logic [2:0]    cmd_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;
  logic          local_q;

  wire take     = core_valid && core_ready;
  wire do_local = core_noacc || (core_write && core_locked && core_lockfail);

  logic [2:0] cmd_enc;
  always_comb begin
    if (!core_write)      cmd_enc = core_locked ? C_RDLK : C_RD;
    else if (core_locked) cmd_enc = C_WRCOND;
    else if (core_swap)   cmd_enc = C_SWAP;
    else                  cmd_enc = C_WR;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cmd_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      local_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (take) begin
          cmd_q   <= cmd_enc;
          addr_q  <= core_addr;
          wdata_q <= core_wdata;
          local_q <= do_local;
          rdata_q <= '0;
          st      <= do_local ? S_RESP : S_ISSUE;
        end
        S_ISSUE: st <= dn_ready ? S_WAIT : S_HOLD;
        S_HOLD:  if (dn_retry) st <= S_ISSUE;
        S_WAIT:  if (up_valid) begin
          if (up_nack) st <= S_ISSUE;
          else begin
            rdata_q <= up_data;
            st      <= S_RESP;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign core_ready = (st == S_IDLE) && !drain_req;
  assign drain_ack  = (st == S_IDLE) && drain_req;
  assign dn_valid   = (st == S_ISSUE);
  assign dn_cmd     = cmd_q;
  assign dn_addr    = addr_q;
  assign dn_wdata   = wdata_q;
  assign rsp_valid  = (st == S_RESP);
  assign rsp_data   = rdata_q;
  assign rsp_local  = local_q;
  assign proto_err  = dn_retry && (st != S_HOLD);

  p_refuse_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && !dn_ready |=> !dn_valid && !core_ready);

  p_retry_resend_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HOLD) && dn_retry |=> dn_valid && $stable(dn_cmd) && $stable(dn_addr));

  p_nack_resend_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT) && up_valid && up_nack |=> dn_valid && $stable(dn_addr));

  p_strobe_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_one_inflight_r9: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !core_ready until_with rsp_valid);

  p_drain_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    drain_ack |-> !dn_valid && !rsp_valid && !core_ready);
endmodule

// File: tb/sim_memreq_seq.sv
module sim_memreq_seq;
  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic core_valid = 0, core_write = 0, core_locked = 0, core_swap = 0, core_noacc = 0, core_lockfail = 0;
  logic [31:0] core_addr = 0, core_wdata = 0, up_data = 0;
  logic dn_ready = 0, dn_retry = 0, up_valid = 0, up_nack = 0, drain_req = 0;
  logic core_ready, rsp_valid, rsp_local, dn_valid, proto_err, drain_ack;
  logic [31:0] rsp_data, dn_addr, dn_wdata;
  logic [2:0] dn_cmd;

  memreq_seq u0 (.clk(clk), .rst_n(rst_n), .core_valid(core_valid), .core_ready(core_ready),
    .core_write(core_write), .core_locked(core_locked), .core_swap(core_swap),
    .core_noacc(core_noacc), .core_lockfail(core_lockfail), .core_addr(core_addr),
    .core_wdata(core_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_local(rsp_local),
    .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_cmd(dn_cmd), .dn_addr(dn_addr),
    .dn_wdata(dn_wdata), .dn_retry(dn_retry), .up_valid(up_valid), .up_nack(up_nack),
    .up_data(up_data), .proto_err(proto_err), .drain_req(drain_req), .drain_ack(drain_ack));

  int tests = 0, fails = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    chk(act === exp, req, act, exp);
  endtask

  // {wr, lk, sw, na, lf, refuse, nack, local, cmd[2:0]}
  localparam int NV = 9;
  localparam logic [10:0] VEC [NV] = '{
    11'b0_0_0_0_0_0_0_0_000,
    11'b0_1_0_0_0_1_0_0_001,
    11'b1_0_0_0_0_0_1_0_010,
    11'b1_1_0_0_0_0_0_0_011,
    11'b1_0_1_0_0_1_0_0_100,
    11'b1_1_1_0_0_0_0_0_011,
    11'b1_1_0_0_1_0_0_1_000,
    11'b0_0_0_1_0_0_0_1_000,
    11'b0_0_1_0_0_0_0_0_000
  };

  task automatic offer(input logic wr, lk, sw, na, lf, input logic [31:0] a, d);
    core_valid = 1; core_write = wr; core_locked = lk; core_swap = sw;
    core_noacc = na; core_lockfail = lf; core_addr = a; core_wdata = d;
    @(posedge clk); @(negedge clk);
    core_valid = 0; core_write = 0; core_locked = 0; core_swap = 0; core_noacc = 0; core_lockfail = 0;
  endtask

  task automatic accept_now();
    dn_ready = 1; @(posedge clk); @(negedge clk); dn_ready = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    eq("R1 core_ready", core_ready, 1);
    eq("R1 dn_valid", dn_valid, 0);
    eq("R1 rsp_valid", rsp_valid, 0);
    eq("R1 drain_ack", drain_ack, 0);

    for (int i = 0; i < NV; i++) begin
      logic [10:0] v;
      logic [31:0] a, d, r;
      v = VEC[i];
      a = 32'h100 + 32'(i) * 4; d = 32'hA000 + 32'(i); r = 32'hD000 + 32'(i);
      offer(v[10], v[9], v[8], v[7], v[6], a, d);
      if (v[3]) begin
        eq("R6/R7 local rsp_valid", rsp_valid, 1);
        eq("R6/R7 rsp_local", rsp_local, 1);
        eq("R6/R7 no bus request", dn_valid, 0);
        eq("R6/R7 rsp_data", rsp_data, 0);
      end else begin
        eq("R2 dn_valid", dn_valid, 1);
        eq("R2 dn_cmd", dn_cmd, v[2:0]);
        eq("R2 dn_addr", dn_addr, a);
        eq("R2 dn_wdata", dn_wdata, d);
        if (v[5]) begin
          @(posedge clk); @(negedge clk);
          eq("R3 held after refusal", dn_valid, 0);
          dn_retry = 1;
          @(posedge clk); @(negedge clk);
          dn_retry = 0;
          eq("R3 resend valid", dn_valid, 1);
          eq("R3 resend cmd", dn_cmd, v[2:0]);
          eq("R3 resend addr", dn_addr, a);
        end
        accept_now();
        if (v[4]) begin
          up_valid = 1; up_nack = 1;
          @(posedge clk); @(negedge clk);
          up_valid = 0; up_nack = 0;
          eq("R4 nack resend", dn_valid, 1);
          eq("R4 nack addr", dn_addr, a);
          accept_now();
        end
        eq("R9 busy", core_ready, 0);
        up_valid = 1; up_data = r;
        @(posedge clk); @(negedge clk);
        up_valid = 0;
        eq("R8 rsp_valid", rsp_valid, 1);
        eq("R8 rsp_data", rsp_data, r);
        eq("R8 rsp_local", rsp_local, 0);
      end
      @(posedge clk); @(negedge clk);
      eq("R8 strobe one cycle", rsp_valid, 0);
      eq("R9 ready again", core_ready, 1);
    end

    // R8: a stray response while idle is ignored
    up_valid = 1; up_data = 32'hBAD;
    @(posedge clk); @(negedge clk);
    up_valid = 0;
    eq("R8 stray response ignored", rsp_valid, 0);

    // R5: retry with nothing held
    dn_retry = 1; #1;
    eq("R5 proto_err", proto_err, 1);
    @(negedge clk); dn_retry = 0; #1;
    eq("R5 proto_err clear", proto_err, 0);

    // R4: nacked resend refused -> wait for retry
    offer(0, 0, 0, 0, 0, 32'h500, 0);
    accept_now();
    up_valid = 1; up_nack = 1;
    @(posedge clk); @(negedge clk);
    up_valid = 0; up_nack = 0;
    eq("R4 resend after nack", dn_valid, 1);
    @(posedge clk); @(negedge clk);
    eq("R4 refused resend held", dn_valid, 0);
    eq("R5 no error while held", proto_err, 0);
    dn_retry = 1;
    @(posedge clk); @(negedge clk);
    dn_retry = 0;
    eq("R4 resend after retry", dn_valid, 1);
    accept_now();
    up_valid = 1; up_data = 32'h5555;
    @(posedge clk); @(negedge clk);
    up_valid = 0;
    eq("R4 final data", rsp_data, 32'h5555);
    @(posedge clk); @(negedge clk);

    // R10: drain while in flight
    offer(1, 0, 0, 0, 0, 32'h600, 32'h66);
    accept_now();
    drain_req = 1; #1;
    eq("R10 no ack in flight", drain_ack, 0);
    up_valid = 1; up_data = 0;
    @(posedge clk); @(negedge clk);
    up_valid = 0;
    eq("R10 no ack on strobe", drain_ack, 0);
    @(posedge clk); @(negedge clk);
    eq("R10 ack after completion", drain_ack, 1);
    eq("R10 held off", core_ready, 0);
    core_valid = 1;
    @(posedge clk); @(negedge clk);
    core_valid = 0;
    eq("R10 offer ignored while draining", dn_valid, 0);
    drain_req = 0; #1;
    eq("R10 ack drops", drain_ack, 0);
    drain_req = 1; #1;
    eq("R10 immediate ack when idle", drain_ack, 1);
    drain_req = 0;

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule